// File: doc/BRIEF.md
# Physical Memory Region Decoder

This block sits on the address path between a 32-bit bus master and a group of on-chip memories. For each request (byte, halfword or word) it compares the address against four base/size windows. A window hits only when the whole access fits inside it. The block then reports which backing memory serves the access and the offset of the access inside that memory. A window whose size is zero never hits.

Each aligned 32-bit word carries three attribute bits, held outside the block and looked up through a small combinational port. The attributes can veto a write (read-only) or request a debug event on a read or on a write (watchpoints). A request that hits no window, or that uses the reserved size code, is a bad access. Its write is dropped, its read data is forced to zero and an error is flagged. The fourth window is an optional alias of the first window: it has the same size and is served by the same backing memory.

Results are registered once and appear in the cycle after the request strobe. The debug event is a one-cycle pulse that carries the physical address and a read/write flag. The access that raised it still completes.

Top module: `phys_region_decoder`

## Requirements
- R1: A window hits when off = addr - base satisfies off < size and nbytes <= size - off, where size code 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. A window of size zero never hits, so the alias window misses when it is disabled.
- R2: The default windows are: index 0 at 0x00000000 with size 0x80000 (backing region 0); index 1 at 0x10000000 with size SDRAM_SIZE, default 0x02000000 (backing region 1); index 2 at 0xA4000000 with size 0x20000 (backing region 2).
- R3: Window 3, enabled by MIRROR_EN, sits at 0xF0000000 with the size of window 0. A hit in window 3 reports backing region 0 and the offset from 0xF0000000. rsp_region is never 3.
- R4: When windows overlap, the lowest-index hitting window sets rsp_region and rsp_offset.
- R5: A request that hits no window gives rsp_hit=0, rsp_err=1, mem_we=0, rsp_region=0, rsp_offset=0 and rsp_rdata=0.
- R6: Size code 3 is reserved. It gives rsp_hit=0 and rsp_err=1, with no write and no debug event.
- R7: attr_addr equals req_addr with bits [1:0] cleared, in the same cycle as the request. attr_flags bit 0 is read-only, bit 1 is read watchpoint and bit 2 is write watchpoint.
- R8: A write that hits a word whose read-only bit is set gives rsp_hit=1, rsp_err=1 and mem_we=0. A read of that word completes normally.
- R9: A read that hits a word whose read-watchpoint bit is set pulses dbg_evt with dbg_is_write=0 and dbg_addr=req_addr, and returns mem_rdata. A write to that word raises no event.
- R10: A write that hits a word whose write-watchpoint bit is set pulses dbg_evt with dbg_is_write=1 and dbg_addr=req_addr, and still asserts mem_we. A read of that word raises no event.
- R11: An access that ends in error (miss, reserved size or read-only write) never raises dbg_evt.
- R12: rsp_valid follows req_valid by exactly one cycle. dbg_evt, mem_we and rsp_err are low in any cycle without rsp_valid, so each event is a single-cycle pulse. rsp_rdata is mem_rdata for a good read and zero otherwise.
- R13: While rst_n is low, every output except attr_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 32 | Physical byte address |
| attr_addr | output | 32 | Word address for the attribute lookup |
| attr_flags | input | 3 | Attributes of the word at attr_addr |
| mem_rdata | input | 32 | Read data from the selected memory, response cycle |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_hit | output | 1 | A window hit with a legal size |
| rsp_err | output | 1 | Bad access |
| rsp_region | output | 2 | Backing memory select |
| rsp_offset | output | 32 | Byte offset inside the backing memory |
| mem_we | output | 1 | Write enable to the selected memory |
| rsp_rdata | output | 32 | Read data, zero on error or on a write |
| dbg_evt | output | 1 | Watchpoint pulse |
| dbg_is_write | output | 1 | The event came from a write |
| dbg_addr | output | 32 | Physical address that raised the event |

## Verification
The attribute lookup address is combinational. The bench checks it shortly after driving the request, in the request cycle. Every other result passes through one register and is due in the cycle after the strobe. The bench drives on the falling edge and samples those results on the next falling edge, which is half a cycle after the capturing rising edge. One more falling edge later, with no request pending, the bench checks that the response strobe, write enable, error and debug pulse have all returned low.

// File: rtl/pmrd_pkg.sv
package pmrd_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned NUM_WIN = 4;
  localparam int unsigned REG_W   = $clog2(NUM_WIN);
  localparam int unsigned ATTR_W  = 3;
  localparam int unsigned ATTR_RO     = 0;
  localparam int unsigned ATTR_RWATCH = 1;
  localparam int unsigned ATTR_WWATCH = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Number of bytes touched by a size code (zero for the reserved code)
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: return 4'd1;
      SZ_HALF: return 4'd2;
      SZ_WORD: return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

  // Whole access lies inside [base, base+size)
  function automatic logic win_fits(input logic [AW-1:0] addr,
                                    input logic [AW-1:0] base,
                                    input logic [AW-1:0] size,
                                    input logic [3:0]    nbytes);
    logic [AW-1:0] off;
    off = addr - base;
    return (off < size) && ({{(AW-4){1'b0}}, nbytes} <= (size - off));
  endfunction

  function automatic logic [AW-1:0] word_align(input logic [AW-1:0] addr);
    return {addr[AW-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/pmrd_win_cmp.sv
module pmrd_win_cmp
  import pmrd_pkg::*;
(
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] size,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    nbytes,
  output logic          hit,
  output logic [AW-1:0] offset
);
  assign offset = addr - base;
  assign hit    = win_fits(addr, base, size, nbytes);
endmodule

// File: rtl/pmrd_prio_sel.sv
module pmrd_prio_sel #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  hit,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Scan from the top so the lowest index is written last and wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pmrd_access_ctl.sv
module pmrd_access_ctl
  import pmrd_pkg::*;
(
  input  logic              req_write,
  input  logic              size_ok,
  input  logic              win_hit,
  input  logic [ATTR_W-1:0] flags,
  output logic              acc_err,
  output logic              acc_we,
  output logic              acc_dbg
);
  logic ro_veto;
  logic acc_good;

  assign ro_veto  = win_hit & size_ok & req_write & flags[ATTR_RO];
  assign acc_good = win_hit & size_ok & ~ro_veto;
  assign acc_err  = ~acc_good;
  assign acc_we   = acc_good & req_write;
  assign acc_dbg  = acc_good & (req_write ? flags[ATTR_WWATCH] : flags[ATTR_RWATCH]);
endmodule

// File: rtl/phys_region_decoder.sv
module phys_region_decoder
  import pmrd_pkg::*;
#(
  parameter logic [31:0] ROM_BASE    = 32'h0000_0000,
  parameter logic [31:0] ROM_SIZE    = 32'h0008_0000,
  parameter logic [31:0] SDRAM_BASE  = 32'h1000_0000,
  parameter logic [31:0] SDRAM_SIZE  = 32'h0200_0000,
  parameter logic [31:0] SRAM_BASE   = 32'hA400_0000,
  parameter logic [31:0] SRAM_SIZE   = 32'h0002_0000,
  parameter logic [31:0] MIRROR_BASE = 32'hF000_0000,
  parameter bit          MIRROR_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  output logic [AW-1:0]     attr_addr,
  input  logic [ATTR_W-1:0] attr_flags,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic [REG_W-1:0]  rsp_region,
  output logic [AW-1:0]     rsp_offset,
  output logic              mem_we,
  output logic [31:0]       rsp_rdata,
  output logic              dbg_evt,
  output logic              dbg_is_write,
  output logic [AW-1:0]     dbg_addr
);
  localparam logic [31:0] MIRROR_SIZE = MIRROR_EN ? ROM_SIZE : 32'd0;
  localparam logic [NUM_WIN-1:0][AW-1:0] WBASE =
    {MIRROR_BASE, SRAM_BASE, SDRAM_BASE, ROM_BASE};
  localparam logic [NUM_WIN-1:0][AW-1:0] WSIZE =
    {MIRROR_SIZE, SRAM_SIZE, SDRAM_SIZE, ROM_SIZE};
  // Backing memory of each window; the alias shares window 0's storage
  localparam logic [NUM_WIN-1:0][REG_W-1:0] WBACK =
    {REG_W'(0), REG_W'(2), REG_W'(1), REG_W'(0)};

  // Named internal events
  logic [NUM_WIN-1:0]         win_hit;
  logic [NUM_WIN-1:0][AW-1:0] win_off;
  logic                       any_hit;
  logic [REG_W-1:0]           hit_idx;
  logic                       size_ok;
  logic                       sel_hit;
  logic [3:0]                 nbytes;
  logic                       acc_err;
  logic                       acc_we;
  logic                       acc_dbg;

  assign nbytes    = size_bytes(req_size);
  assign size_ok   = (req_size != SZ_RSVD);
  assign sel_hit   = any_hit & size_ok;
  assign attr_addr = word_align(req_addr);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    pmrd_win_cmp u_cmp (
      .base   (WBASE[g]),
      .size   (WSIZE[g]),
      .addr   (req_addr),
      .nbytes (nbytes),
      .hit    (win_hit[g]),
      .offset (win_off[g])
    );
  end

  pmrd_prio_sel #(.N(NUM_WIN), .IW(REG_W)) u_prio (
    .hit   (win_hit),
    .found (any_hit),
    .idx   (hit_idx)
  );

  pmrd_access_ctl u_ctl (
    .req_write (req_write),
    .size_ok   (size_ok),
    .win_hit   (any_hit),
    .flags     (attr_flags),
    .acc_err   (acc_err),
    .acc_we    (acc_we),
    .acc_dbg   (acc_dbg)
  );

  logic wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_region   <= '0;
      rsp_offset   <= '0;
      mem_we       <= 1'b0;
      dbg_evt      <= 1'b0;
      dbg_is_write <= 1'b0;
      dbg_addr     <= '0;
      wr_q         <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= req_valid & sel_hit;
      rsp_err      <= req_valid & acc_err;
      rsp_region   <= (req_valid && sel_hit) ? WBACK[hit_idx] : '0;
      rsp_offset   <= (req_valid && sel_hit) ? win_off[hit_idx] : '0;
      mem_we       <= req_valid & acc_we;
      dbg_evt      <= req_valid & acc_dbg;
      dbg_is_write <= req_valid & acc_dbg & req_write;
      wr_q         <= req_write;
      if (req_valid && acc_dbg) dbg_addr <= req_addr;
    end
  end

  assign rsp_rdata = (rsp_valid && !rsp_err && !wr_q) ? mem_rdata : 32'd0;
endmodule

// File: rtl/phys_region_decoder_chk.sv
module phys_region_decoder_chk
  import pmrd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_err,
  input logic [REG_W-1:0] rsp_region,
  input logic             mem_we,
  input logic [31:0]      rsp_rdata,
  input logic             dbg_evt,
  input logic             dbg_is_write
);
  p_err_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'd0));

  p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !mem_we);

  p_err_no_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !dbg_evt);

  p_alias_backing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_region != REG_W'(3)));

  p_rsp_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!dbg_evt && !mem_we && !rsp_err && !rsp_hit));

  p_dir_needs_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_is_write |-> dbg_evt);

  p_reserved_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit || rsp_err));
endmodule

bind phys_region_decoder phys_region_decoder_chk u_chk (.*);

// File: tb/phys_region_decoder_tb.sv
module phys_region_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = 32'd0;
  logic [2:0]  attr_flags = 3'd0;
  logic [31:0] mem_rdata = 32'hDEAD_BEEF;

  logic [31:0] attr_addr, rsp_offset, rsp_rdata, dbg_addr;
  logic        rsp_valid, rsp_hit, rsp_err, mem_we, dbg_evt, dbg_is_write;
  logic [1:0]  rsp_region;

  logic [31:0] o_attr_addr, o_offset, o_rdata, o_dbg_addr;
  logic        o_valid, o_hit, o_err, o_we, o_dbg, o_dbgw;
  logic [1:0]  o_region;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  phys_region_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .attr_addr(attr_addr),
    .attr_flags(attr_flags), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_region(rsp_region),
    .rsp_offset(rsp_offset), .mem_we(mem_we), .rsp_rdata(rsp_rdata),
    .dbg_evt(dbg_evt), .dbg_is_write(dbg_is_write), .dbg_addr(dbg_addr)
  );

  // Overlapping map: window 1 covers the upper half of window 0, alias disabled
  phys_region_decoder #(
    .SDRAM_BASE(32'h0004_0000), .SDRAM_SIZE(32'h0008_0000), .MIRROR_EN(1'b0)
  ) u_ovl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .attr_addr(o_attr_addr),
    .attr_flags(attr_flags), .mem_rdata(mem_rdata), .rsp_valid(o_valid),
    .rsp_hit(o_hit), .rsp_err(o_err), .rsp_region(o_region),
    .rsp_offset(o_offset), .mem_we(o_we), .rsp_rdata(o_rdata),
    .dbg_evt(o_dbg), .dbg_is_write(o_dbgw), .dbg_addr(o_dbg_addr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]  req;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [2:0]  fl;   // bit0 read-only, bit1 read watch, bit2 write watch
    logic        hit;
    logic        err;
    logic [1:0]  rg;
    logic [31:0] off;
    logic        we;
    logic        dbg;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  1'b0, 2'd2, 32'h0000_0100, 3'd0, 1'b1, 1'b0, 2'd0, 32'h0000_0100, 1'b0, 1'b0}, // R2 ROM word
    '{8'd1,  1'b0, 2'd2, 32'h0007_FFFC, 3'd0, 1'b1, 1'b0, 2'd0, 32'h0007_FFFC, 1'b0, 1'b0}, // R1 last word
    '{8'd1,  1'b0, 2'd2, 32'h0007_FFFE, 3'd0, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0}, // R1 word straddles end
    '{8'd1,  1'b0, 2'd1, 32'h0007_FFFE, 3'd0, 1'b1, 1'b0, 2'd0, 32'h0007_FFFE, 1'b0, 1'b0}, // R1 half fits
    '{8'd1,  1'b0, 2'd0, 32'h0007_FFFF, 3'd0, 1'b1, 1'b0, 2'd0, 32'h0007_FFFF, 1'b0, 1'b0}, // R1 last byte
    '{8'd5,  1'b1, 2'd2, 32'h0008_0000, 3'd0, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0}, // R5 write miss
    '{8'd2,  1'b1, 2'd2, 32'h1000_0040, 3'd0, 1'b1, 1'b0, 2'd1, 32'h0000_0040, 1'b1, 1'b0}, // R2 SDRAM write
    '{8'd2,  1'b0, 2'd2, 32'h11FF_FFFC, 3'd0, 1'b1, 1'b0, 2'd1, 32'h01FF_FFFC, 1'b0, 1'b0}, // R2 SDRAM end
    '{8'd5,  1'b0, 2'd0, 32'h1200_0000, 3'd0, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0}, // R5 past SDRAM
    '{8'd2,  1'b1, 2'd1, 32'hA401_FFFE, 3'd0, 1'b1, 1'b0, 2'd2, 32'h0001_FFFE, 1'b1, 1'b0}, // R2 SRAM end
    '{8'd5,  1'b0, 2'd2, 32'hA402_0000, 3'd0, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0}, // R5 past SRAM
    '{8'd3,  1'b0, 2'd2, 32'hF000_0010, 3'd0, 1'b1, 1'b0, 2'd0, 32'h0000_0010, 1'b0, 1'b0}, // R3 alias
    '{8'd3,  1'b0, 2'd0, 32'hF007_FFFF, 3'd0, 1'b1, 1'b0, 2'd0, 32'h0007_FFFF, 1'b0, 1'b0}, // R3 alias end
    '{8'd3,  1'b0, 2'd0, 32'hF008_0000, 3'd0, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0}, // R3 past alias
    '{8'd8,  1'b1, 2'd2, 32'h0000_0100, 3'd1, 1'b1, 1'b1, 2'd0, 32'h0000_0100, 1'b0, 1'b0}, // R8 RO write
    '{8'd8,  1'b0, 2'd2, 32'h0000_0100, 3'd1, 1'b1, 1'b0, 2'd0, 32'h0000_0100, 1'b0, 1'b0}, // R8 RO read
    '{8'd9,  1'b0, 2'd0, 32'h1000_0103, 3'd2, 1'b1, 1'b0, 2'd1, 32'h0000_0103, 1'b0, 1'b1}, // R9 read watch
    '{8'd9,  1'b1, 2'd2, 32'h1000_0100, 3'd2, 1'b1, 1'b0, 2'd1, 32'h0000_0100, 1'b1, 1'b0}, // R9 write ignored
    '{8'd10, 1'b1, 2'd0, 32'hA400_0005, 3'd4, 1'b1, 1'b0, 2'd2, 32'h0000_0005, 1'b1, 1'b1}, // R10 write watch
    '{8'd10, 1'b0, 2'd2, 32'hA400_0004, 3'd4, 1'b1, 1'b0, 2'd2, 32'h0000_0004, 1'b0, 1'b0}, // R10 read ignored
    '{8'd11, 1'b1, 2'd2, 32'h0000_0200, 3'd5, 1'b1, 1'b1, 2'd0, 32'h0000_0200, 1'b0, 1'b0}, // R11 RO+watch
    '{8'd11, 1'b0, 2'd2, 32'h5000_0000, 3'd2, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0}, // R11 miss+watch
    '{8'd6,  1'b0, 2'd3, 32'h0000_0100, 3'd0, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0}  // R6 reserved size
  };

  task automatic issue(input logic wr, input logic [1:0] sz,
                       input logic [31:0] addr, input logic [2:0] fl);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_size   = sz;
    req_addr   = addr;
    attr_flags = fl;
    #1;
    chk("R7", "attr_addr", attr_addr, addr & ~32'd3);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R13 reset state
    repeat (3) @(negedge clk);
    chk("R13", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R13", "rsp_err",   {31'd0, rsp_err},   32'd0);
    chk("R13", "dbg_evt",   {31'd0, dbg_evt},   32'd0);
    chk("R13", "mem_we",    {31'd0, mem_we},    32'd0);
    chk("R13", "rsp_rdata", rsp_rdata,          32'd0);
    chk("R13", "rsp_offset", rsp_offset,        32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VEC[i];
      t = $sformatf("R%0d", v.req);
      issue(v.wr, v.sz, v.addr, v.fl);
      chk(t, "rsp_valid",  {31'd0, rsp_valid},  32'd1);
      chk(t, "rsp_hit",    {31'd0, rsp_hit},    {31'd0, v.hit});
      chk(t, "rsp_err",    {31'd0, rsp_err},    {31'd0, v.err});
      chk(t, "rsp_region", {30'd0, rsp_region}, {30'd0, v.rg});
      chk(t, "rsp_offset", rsp_offset,          v.off);
      chk(t, "mem_we",     {31'd0, mem_we},     {31'd0, v.we});
      chk(t, "dbg_evt",    {31'd0, dbg_evt},    {31'd0, v.dbg});
      chk(t, "dbg_is_write", {31'd0, dbg_is_write}, {31'd0, v.dbg & v.wr});
      if (v.dbg) chk(t, "dbg_addr", dbg_addr, v.addr);
      chk(t, "rsp_rdata", rsp_rdata, (!v.err && !v.wr) ? 32'hDEAD_BEEF : 32'd0);
      // R12 the pulse ends once no request is pending
      @(negedge clk);
      chk("R12", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R12", "idle dbg_evt",   {31'd0, dbg_evt},   32'd0);
      chk("R12", "idle mem_we",    {31'd0, mem_we},    32'd0);
      chk("R12", "idle rsp_err",   {31'd0, rsp_err},   32'd0);
    end

    // R4 overlap: lowest index wins, then window 1 beyond window 0
    issue(1'b0, 2'd2, 32'h0004_0010, 3'd0);
    chk("R4", "ovl region", {30'd0, o_region}, 32'd0);
    chk("R4", "ovl offset", o_offset, 32'h0004_0010);
    issue(1'b0, 2'd2, 32'h0008_0010, 3'd0);
    chk("R4", "ovl region hi", {30'd0, o_region}, 32'd1);
    chk("R4", "ovl offset hi", o_offset, 32'h0004_0010);
    // R1 zero-size (disabled) alias window never hits
    issue(1'b0, 2'd2, 32'hF000_0010, 3'd0);
    chk("R1", "disabled alias err", {31'd0, o_err}, 32'd1);
    chk("R1", "disabled alias hit", {31'd0, o_hit}, 32'd0);
    chk("R3", "enabled alias hit", {31'd0, rsp_hit}, 32'd1);

    // R12 back-to-back requests: both respond, in order
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2;
    req_addr = 32'h1000_0000; attr_flags = 3'd2;
    @(negedge clk);
    chk("R12", "b2b first dbg", {31'd0, dbg_evt}, 32'd1);
    chk("R12", "b2b first addr", dbg_addr, 32'h1000_0000);
    req_addr = 32'h1000_0008; attr_flags = 3'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12", "b2b second valid", {31'd0, rsp_valid}, 32'd1);
    chk("R12", "b2b second dbg", {31'd0, dbg_evt}, 32'd0);
    chk("R12", "b2b second offset", rsp_offset, 32'h0000_0008);

    // R13 reset mid-stream clears the outputs
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; attr_flags = 3'd4;
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R13", "reset dbg_evt", {31'd0, dbg_evt}, 32'd0);
    chk("R13", "reset mem_we",  {31'd0, mem_we},  32'd0);
    chk("R13", "reset dbg_addr", dbg_addr, 32'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule